// File: doc/BRIEF.md
# Two-Wire Interface Control and Acknowledge Logic

This block holds the control byte of a two-wire serial interface and runs the handshake between the CPU and the bus engine. When the engine finishes a job, it raises a service flag. The flag holds the clock line low, and it can request an interrupt. Software answers by writing a one to the flag bit. That write clears the flag and, when the interface is enabled, sends a single-cycle launch pulse to the engine.

The block also makes the acknowledge decision for received bytes. An acknowledge is given only when the acknowledge-enable bit is set and the received item is one of these three:
- the device's own address;
- a general-call address, while general-call recognition is on;
- a data byte received in a receiver mode.

Anything else gets a not-acknowledge. A write-collision bit records data-register writes that arrive while the flag is clear. The bus shifter and the clock generation sit outside this block.

Top module: `twi_ctrl_core`

## Requirements
- R1: After reset, the control readback is 0x00 and irq, go_pulse, scl_stretch, ack_valid and ack_bit are all 0.
- R2: A cycle with job_done high sets the service flag (readback bit 7) from the next cycle on. This holds even when a flag-clearing write arrives in the same cycle: the set wins.
- R3: A control write with data bit 7 = 1 clears the service flag from the next cycle on. A control write with data bit 7 = 0 leaves the flag unchanged.
- R4: go_pulse is high for exactly the one cycle after a control write that has data bit 7 = 1 and data bit 2 (enable) = 1, made while the flag was set. No other write produces it.
- R5: irq is high exactly when the flag, the interrupt-enable bit (bit 0) and glb_irq_en are all 1.
- R6: scl_stretch equals the service flag in every cycle.
- R7: Bits 6 (ack enable), 5 (start), 4 (stop), 2 (enable) and 0 (interrupt enable) take the written data. Bits 3 and 1 are not changed by control writes, and bit 1 always reads 0. start_req, stop_req and core_en follow bits 5, 4 and 2.
- R8: One cycle after any of own_addr_hit, gen_call_hit or rx_byte_done is high, ack_valid pulses for one cycle. With bit 6 set, ack_bit is 1 (ACK) for an own-address or data-byte event.
- R9: For a general-call event, ack_bit is 1 only if both bit 6 and gc_enable are 1. Otherwise it is 0 (NACK).
- R10: With bit 6 clear, every event gives ack_bit = 0.
- R11: A data-register write (dat_wr) made while the flag is clear sets bit 3 in the next cycle. A data-register write made while the flag is set clears bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data for the control register |
| dat_wr | input | 1 | Data register write strobe |
| glb_irq_en | input | 1 | Global interrupt enable |
| gc_enable | input | 1 | General-call recognition enabled |
| job_done | input | 1 | Bus engine finished its current job |
| own_addr_hit | input | 1 | Own slave address received |
| gen_call_hit | input | 1 | General-call address received |
| rx_byte_done | input | 1 | Data byte received in a receiver mode |
| ctl_rdata | output | 8 | Control register readback |
| irq | output | 1 | Interrupt request |
| go_pulse | output | 1 | One-cycle launch pulse to the bus engine |
| scl_stretch | output | 1 | Hold the clock line low |
| start_req | output | 1 | Start condition requested |
| stop_req | output | 1 | Stop condition requested |
| core_en | output | 1 | Interface enabled |
| ack_valid | output | 1 | ack_bit is valid this cycle |
| ack_bit | output | 1 | 1 = drive ACK, 0 = drive NACK |

## Verification
The flag handshake is tried with several writes:
- a write of one while the flag is set, with the enable bit on and with it off, which separates clearing the flag from launching the engine;
- a write of zero, which must change nothing;
- a clearing write in the same cycle as job_done, which settles the priority.

Each of the three acknowledge events is applied with ack enable on and off, and the general call is also applied with recognition on and off, so that every term of the acknowledge decision is shown to matter. Data-register writes with the flag set and with it clear show both the set and the clear path of the collision bit. Interrupt gating is walked through each missing enable.

// File: rtl/twi_ctrl_pkg.sv
// Package: bit positions and widths shared by the two-wire control logic.
// Assumes an 8-bit control register; the bit order is decoded by software.
package twi_ctrl_pkg;
    localparam int unsigned CTL_W   = 8;
    localparam int unsigned B_FLAG  = 7;
    localparam int unsigned B_ACKEN = 6;
    localparam int unsigned B_START = 5;
    localparam int unsigned B_STOP  = 4;
    localparam int unsigned B_WCOL  = 3;
    localparam int unsigned B_RSVD  = 1;
    localparam int unsigned B_EN    = 2;
    localparam int unsigned B_IE    = 0;
    // Bits loaded directly from a control write.
    localparam logic [CTL_W-1:0] WR_MASK = 8'b0111_0101;

    typedef struct packed {
        logic own;
        logic gcall;
        logic rxb;
    } ack_ev_t;
endpackage

// File: rtl/twi_ctrl_flag.sv
// Module: service flag and launch pulse.
// Sets the flag on job completion and clears it on a write-one. A hardware set
// in the same cycle as a clear wins. Emits a registered one-cycle launch pulse
// when the flag is cleared with the enable bit written as one.
module twi_ctrl_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic launch_ok_i,
    output logic flag_o,
    output logic go_o
);
    logic flag_q;
    logic go_q;

    // Flag register: the set has priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    // Launch pulse: one cycle, only when a set flag is cleared with enable on.
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= clr_i & flag_q & launch_ok_i;
    end

    assign flag_o = flag_q;
    assign go_o   = go_q;
endmodule

// File: rtl/twi_ctrl_ack.sv
// Module: acknowledge decision.
// Turns receive events into a registered valid pulse and an ACK/NACK bit.
// Assumes the bus engine pulses at most one event class per byte.
module twi_ctrl_ack
    import twi_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ack_ev_t ev_i,
    input  logic    ack_en_i,
    input  logic    gc_en_i,
    output logic    valid_o,
    output logic    ack_o
);
    logic any_ev;
    logic qualify;
    logic valid_q;
    logic ack_q;

    // Decision: ACK needs ack enable and one qualifying event.
    always_comb begin
        any_ev  = ev_i.own | ev_i.gcall | ev_i.rxb;
        qualify = ev_i.own | ev_i.rxb | (ev_i.gcall & gc_en_i);
    end

    // Output register: pulse valid with the decided bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            valid_q <= any_ev;
            ack_q   <= any_ev & ack_en_i & qualify;
        end
    end

    assign valid_o = valid_q;
    assign ack_o   = ack_q;
endmodule

// File: rtl/twi_ctrl_wcol.sv
// Module: write-collision tracker.
// Sets on a data write made while the flag is clear; clears on a data write
// made while the flag is set. Holds otherwise.
module twi_ctrl_wcol (
    input  logic clk,
    input  logic rst_n,
    input  logic dat_wr_i,
    input  logic flag_i,
    output logic wcol_o
);
    logic wcol_q;

    // Collision state update on data-register writes only.
    always_ff @(posedge clk) begin
        if (!rst_n)        wcol_q <= 1'b0;
        else if (dat_wr_i) wcol_q <= ~flag_i;
    end

    assign wcol_o = wcol_q;
endmodule

// File: rtl/twi_ctrl_core.sv
// Module: top of the two-wire control and acknowledge logic.
// Holds the writable control bits, assembles the readback byte and gates the
// interrupt. Assumes single-cycle write strobes from the CPU bus.
module twi_ctrl_core
    import twi_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             dat_wr,
    input  logic             glb_irq_en,
    input  logic             gc_enable,
    input  logic             job_done,
    input  logic             own_addr_hit,
    input  logic             gen_call_hit,
    input  logic             rx_byte_done,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic             irq,
    output logic             go_pulse,
    output logic             scl_stretch,
    output logic             start_req,
    output logic             stop_req,
    output logic             core_en,
    output logic             ack_valid,
    output logic             ack_bit
);
    logic [CTL_W-1:0] cfg_q;
    logic             flag;
    logic             wcol;
    ack_ev_t          ev;

    // Writable configuration bits, one register per masked position.
    for (genvar i = 0; i < CTL_W; i++) begin : g_cfg
        if (WR_MASK[i]) begin : g_wr
            // Load the bit on a control write.
            always_ff @(posedge clk) begin
                if (!rst_n)      cfg_q[i] <= 1'b0;
                else if (ctl_wr) cfg_q[i] <= wr_data[i];
            end
        end else begin : g_ro
            assign cfg_q[i] = 1'b0;
        end
    end

    twi_ctrl_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (job_done),
        .clr_i      (ctl_wr & wr_data[B_FLAG]),
        .launch_ok_i(wr_data[B_EN]),
        .flag_o     (flag),
        .go_o       (go_pulse)
    );

    twi_ctrl_wcol u_wcol (
        .clk     (clk),
        .rst_n   (rst_n),
        .dat_wr_i(dat_wr),
        .flag_i  (flag),
        .wcol_o  (wcol)
    );

    // Gather the receive events into one record.
    always_comb begin
        ev.own   = own_addr_hit;
        ev.gcall = gen_call_hit;
        ev.rxb   = rx_byte_done;
    end

    twi_ctrl_ack u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev),
        .ack_en_i(cfg_q[B_ACKEN]),
        .gc_en_i (gc_enable),
        .valid_o (ack_valid),
        .ack_o   (ack_bit)
    );

    // Readback byte and outward control signals.
    always_comb begin
        ctl_rdata         = cfg_q;
        ctl_rdata[B_FLAG] = flag;
        ctl_rdata[B_WCOL] = wcol;
        ctl_rdata[B_RSVD] = 1'b0;
        irq               = flag & cfg_q[B_IE] & glb_irq_en;
        scl_stretch       = flag;
        start_req         = cfg_q[B_START];
        stop_req          = cfg_q[B_STOP];
        core_en           = cfg_q[B_EN];
    end
endmodule

// File: rtl/twi_ctrl_chk.sv
// Module: assertion checker bound to twi_ctrl_core.
module twi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [7:0] wr_data,
    input logic       dat_wr,
    input logic       glb_irq_en,
    input logic       job_done,
    input logic [7:0] ctl_rdata,
    input logic       irq,
    input logic       go_pulse,
    input logic       scl_stretch,
    input logic       ack_valid,
    input logic       ack_bit
);
    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |=> ctl_rdata[7]);

    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data[7] && !job_done) |=> !ctl_rdata[7]);

    assert_zero_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wr_data[7] && ctl_rdata[7]) |=> ctl_rdata[7]);

    assert_go_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_data[7] && wr_data[2] && ctl_rdata[7]) |=> go_pulse);

    assert_go_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |=> !go_pulse);

    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (ctl_rdata[7] && ctl_rdata[0] && glb_irq_en));

    assert_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scl_stretch == ctl_rdata[7]);

    assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[1]);

    assert_ack_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_bit) |-> $past(ctl_rdata[6]));

    assert_wcol_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !ctl_rdata[7]) |=> ctl_rdata[3]);
endmodule

bind twi_ctrl_core twi_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .wr_data    (wr_data),
    .dat_wr     (dat_wr),
    .glb_irq_en (glb_irq_en),
    .job_done   (job_done),
    .ctl_rdata  (ctl_rdata),
    .irq        (irq),
    .go_pulse   (go_pulse),
    .scl_stretch(scl_stretch),
    .ack_valid  (ack_valid),
    .ack_bit    (ack_bit)
);

// File: tb/twi_ctrl_core_tb_top.sv
module twi_ctrl_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       dat_wr = 1'b0;
    logic       glb_irq_en = 1'b0;
    logic       gc_enable = 1'b0;
    logic       job_done = 1'b0;
    logic       own_addr_hit = 1'b0;
    logic       gen_call_hit = 1'b0;
    logic       rx_byte_done = 1'b0;
    logic [7:0] ctl_rdata;
    logic       irq, go_pulse, scl_stretch, start_req, stop_req, core_en;
    logic       ack_valid, ack_bit;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    twi_ctrl_core dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_data(wr_data),
        .dat_wr(dat_wr), .glb_irq_en(glb_irq_en), .gc_enable(gc_enable),
        .job_done(job_done), .own_addr_hit(own_addr_hit),
        .gen_call_hit(gen_call_hit), .rx_byte_done(rx_byte_done),
        .ctl_rdata(ctl_rdata), .irq(irq), .go_pulse(go_pulse),
        .scl_stretch(scl_stretch), .start_req(start_req), .stop_req(stop_req),
        .core_en(core_en), .ack_valid(ack_valid), .ack_bit(ack_bit)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one cycle: inputs already set at a negedge take effect at the next posedge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic ctl_write(input logic [7:0] d);
        ctl_wr = 1'b1; wr_data = d;
        tick();
        ctl_wr = 1'b0; wr_data = 8'h00;
    endtask

    task automatic pulse_done();
        job_done = 1'b1; tick(); job_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", ctl_rdata, 8'h00);
        chk("R1 outs", {irq, go_pulse, scl_stretch, ack_valid, ack_bit}, 8'h00);
    endtask

    task automatic t_config();
        ctl_write(8'hFF);
        chk("R7 writable bits", ctl_rdata, 8'h75);
        chk("R7 start/stop/en", {start_req, stop_req, core_en}, 8'h07);
        ctl_write(8'h0A);
        chk("R7 ro bits ignored", ctl_rdata, 8'h00);
    endtask

    task automatic t_flag();
        ctl_write(8'h04);
        pulse_done();
        chk("R2 flag set", ctl_rdata[7], 1'b1);
        chk("R6 stretch with flag", scl_stretch, 1'b1);
        ctl_write(8'h04);
        chk("R3 write zero keeps flag", ctl_rdata[7], 1'b1);
        chk("R4 no go on zero write", go_pulse, 1'b0);
        ctl_write(8'h84);
        chk("R3 write one clears", ctl_rdata[7], 1'b0);
        chk("R4 go pulse", go_pulse, 1'b1);
        chk("R6 stretch released", scl_stretch, 1'b0);
        tick();
        chk("R4 go one cycle", go_pulse, 1'b0);
        ctl_write(8'h84);
        chk("R4 no go when flag clear", go_pulse, 1'b0);
        pulse_done();
        ctl_write(8'h80);
        chk("R4 no go when enable off", go_pulse, 1'b0);
        chk("R3 cleared without enable", ctl_rdata[7], 1'b0);
    endtask

    task automatic t_coincide();
        pulse_done();
        job_done = 1'b1; ctl_wr = 1'b1; wr_data = 8'h84;
        tick();
        job_done = 1'b0; ctl_wr = 1'b0; wr_data = 8'h00;
        chk("R2 set wins over clear", ctl_rdata[7], 1'b1);
        ctl_write(8'h80);
    endtask

    task automatic t_irq();
        ctl_write(8'h01);
        glb_irq_en = 1'b1; tick();
        chk("R5 no irq without flag", irq, 1'b0);
        pulse_done();
        chk("R5 irq all enables", irq, 1'b1);
        glb_irq_en = 1'b0; tick();
        chk("R5 global off", irq, 1'b0);
        glb_irq_en = 1'b1;
        ctl_write(8'h00);
        chk("R5 local off", irq, 1'b0);
        ctl_write(8'h80);
        glb_irq_en = 1'b0;
    endtask

    task automatic ev(input int which, input logic [7:0] exp, input string req);
        own_addr_hit = (which == 0);
        gen_call_hit = (which == 1);
        rx_byte_done = (which == 2);
        tick();
        own_addr_hit = 1'b0; gen_call_hit = 1'b0; rx_byte_done = 1'b0;
        chk(req, {ack_valid, ack_bit}, exp);
        tick();
        chk({req, " valid drop"}, ack_valid, 1'b0);
    endtask

    task automatic t_ack();
        ctl_write(8'h40);
        ev(0, 8'h03, "R8 own addr ACK");
        ev(2, 8'h03, "R8 rx byte ACK");
        gc_enable = 1'b1;
        ev(1, 8'h03, "R9 gcall enabled ACK");
        gc_enable = 1'b0;
        ev(1, 8'h02, "R9 gcall disabled NACK");
        ctl_write(8'h00);
        ev(0, 8'h02, "R10 own NACK");
        ev(2, 8'h02, "R10 rx NACK");
        gc_enable = 1'b1;
        ev(1, 8'h02, "R10 gcall NACK");
        gc_enable = 1'b0;
    endtask

    task automatic t_wcol();
        dat_wr = 1'b1; tick(); dat_wr = 1'b0;
        chk("R11 collision set", ctl_rdata[3], 1'b1);
        ctl_write(8'h00);
        chk("R7 write keeps wcol", ctl_rdata[3], 1'b1);
        pulse_done();
        dat_wr = 1'b1; tick(); dat_wr = 1'b0;
        chk("R11 collision cleared", ctl_rdata[3], 1'b0);
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_config();
        t_flag();
        t_coincide();
        t_irq();
        t_ack();
        t_wcol();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule